// File: doc/BRIEF.md
# Hardware-Directed Branch Target Unit

This unit serves the program sequencer during a branch whose destination is supplied by hardware outside the core. When the sequencer starts such a branch, the unit raises an index-request strobe for one instruction cycle. The external logic answers by placing an index on the index bus. The unit samples the index once, adds a fixed base address set by a parameter, and holds the sum as the jump target. At the end of the instruction it pulses a program-counter load strobe.

The branch always takes two instruction cycles. Any bus-acknowledge (stall) cycles come after the second cycle, so the index is never sampled again. A step-enable input lets the sequencer freeze the unit. On an edge where step-enable is low, the unit does not advance.

Top module: `hwb_unit`

## Requirements
- R1: The target equals (index + BASE) modulo 2^ADDR_W, with the index zero-extended. It is valid when pc_load is high and stays unchanged until the next index sample. With the defaults (ADDR_W=12, IDX_W=8, BASE=0xF80), index 0x80 gives 0x000 and index 0xFF gives 0x07F.
- R2: An edge with br_start=1 and step_en=1, while the unit is idle, accepts a branch. index_rd is high from that edge to the next advancing edge (one cycle when step_en stays high), and it is low at all other times.
- R3: idx_in is sampled only on the advancing edge that ends the index_rd cycle. Values on idx_in at any other time do not change target.
- R4: pc_load is a single-cycle pulse. With no stall it is high in the cycle after the second advancing edge that follows acceptance.
- R5: Each advancing edge in the second cycle or a stall cycle that sees bus_ack=1 adds one cycle before pc_load. pc_load follows the first such edge that sees bus_ack=0, and index_rd stays low during stall cycles.
- R6: An edge with step_en=0 leaves the progress of the branch, index_rd and target unchanged. It only returns pc_load to 0.
- R7: br_start is ignored while a branch is in progress and on edges with step_en=0.
- R8: Synchronous reset drives index_rd=0, pc_load=0 and target=0, and returns the unit to idle.
- R9: bus_ack has no effect while idle or during the index_rd cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Sequencer advance enable; edges with it low are frozen |
| br_start | input | 1 | Start strobe for a hardware-directed branch |
| bus_ack | input | 1 | Bus-acknowledge stall request |
| idx_in | input | IDX_W | External branch index |
| index_rd | output | 1 | Index request; external logic must drive idx_in while it is high |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| target | output | ADDR_W | Computed jump target |

## Verification
On every cycle, the assertions check the following: index_rd lasts one advancing cycle, pc_load is a lone pulse that follows an edge with no stall, index_rd and pc_load are never high together, index_rd and target do not move on frozen edges, and target holds the wrapped sum of the sampled index. Only the bench scenarios can show the full timing. These scenarios cover the exact cycle in which pc_load appears for each stall length, wrap-around at chosen indices, that the index is not sampled again after idx_in changes, and that br_start and bus_ack are ignored when they arrive at the wrong moment.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SECND = 2'd2,
    ST_STALL = 2'd3
  } hwb_state_e;
endpackage

// File: rtl/hwb_seq.sv
module hwb_seq
  import hwb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic br_start,
  input  logic bus_ack,
  output logic rd_q,
  output logic cap_en,
  output logic load_q
);
  hwb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step_en) begin
      case (state_q)
        ST_IDLE:  if (br_start) state_d = ST_FETCH;
        ST_FETCH: state_d = ST_SECND;
        ST_SECND, ST_STALL: state_d = bus_ack ? ST_STALL : ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  // sample the index on the advancing edge that closes the request cycle
  assign cap_en = step_en && (state_q == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= (state_d == ST_FETCH);
      load_q  <= step_en && !bus_ack &&
                 (state_q == ST_SECND || state_q == ST_STALL);
    end
  end

  // R2: request lasts exactly one advancing cycle
  p_rd_single_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_q && step_en) |=> !rd_q);

  // R4: load strobe is a lone pulse
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q);

  // R5: load only after an advancing edge that saw no stall
  p_load_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(load_q) |-> $past(step_en && !bus_ack));

  // R6: frozen edge keeps the request strobe
  p_freeze_rd_r6: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(rd_q));

  // R2/R4: request and load never overlap
  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && load_q));
endmodule

// File: rtl/hwb_target.sv
module hwb_target #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BASE   = 32'hF80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] tgt_q
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic [ADDR_W-1:0] sum;
  assign sum = ADDR_W'(idx) + BASE_V;   // wraps at ADDR_W bits

  always_ff @(posedge clk) begin
    if (rst)         tgt_q <= '0;
    else if (cap_en) tgt_q <= sum;
  end

  // R3: target moves only on a sampling edge
  p_tgt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(tgt_q));
endmodule

// File: rtl/hwb_unit.sv
module hwb_unit #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BASE   = 32'hF80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              br_start,
  input  logic              bus_ack,
  input  logic [IDX_W-1:0]  idx_in,
  output logic              index_rd,
  output logic              pc_load,
  output logic [ADDR_W-1:0] target
);
  logic cap_en;

  hwb_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .br_start (br_start),
    .bus_ack  (bus_ack),
    .rd_q     (index_rd),
    .cap_en   (cap_en),
    .load_q   (pc_load)
  );

  hwb_target #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_tgt (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .idx    (idx_in),
    .tgt_q  (target)
  );

  // R1: after the sampling edge, target holds the wrapped sum seen at the ports
  p_target_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (index_rd && step_en) |=>
      (target == ADDR_W'(ADDR_W'($past(idx_in)) + ADDR_W'(BASE))));

  // R8/R6: target frozen when no request is pending
  p_target_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !index_rd |=> $stable(target));
endmodule

// File: tb/hwb_unit_tb.sv
module hwb_unit_tb;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 8;
  localparam int BASE   = 'hF80;

  logic clk = 1'b0;
  logic rst, step_en, br_start, bus_ack;
  logic [IDX_W-1:0]  idx_in;
  logic              index_rd, pc_load;
  logic [ADDR_W-1:0] target;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  hwb_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .br_start(br_start),
    .bus_ack(bus_ack), .idx_in(idx_in), .index_rd(index_rd),
    .pc_load(pc_load), .target(target)
  );

  function automatic logic [ADDR_W-1:0] exp_tgt(input logic [IDX_W-1:0] ix);
    int unsigned s;
    s = int'(ix) + BASE;
    return s[ADDR_W-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one branch with nstall bus-ack cycles; stray inputs at ignored moments
  task automatic run_branch(input logic [IDX_W-1:0] ix, input int nstall);
    logic [ADDR_W-1:0] e = exp_tgt(ix);
    @(negedge clk); br_start = 1'b1; step_en = 1'b1; idx_in = ~ix;
    bus_ack = 1'($urandom_range(1));
    @(negedge clk);
    chk("R2 index_rd in first cycle", int'(index_rd), 1);
    chk("R4 no load in first cycle", int'(pc_load), 0);
    idx_in = ix; br_start = 1'b1;                      // R7 stray start
    bus_ack = 1'($urandom_range(1));                   // R9 ignored here
    @(negedge clk);
    br_start = 1'b0;
    chk("R2 index_rd drops", int'(index_rd), 0);
    idx_in = ~ix;                                      // R3 late change
    bus_ack = (nstall > 0);
    for (int i = 0; i < nstall; i++) begin
      @(negedge clk);
      chk("R5 no load while stalled", int'(pc_load), 0);
      chk("R5 no index_rd while stalled", int'(index_rd), 0);
      bus_ack = (i + 1 < nstall);
    end
    @(negedge clk);
    chk("R4 pc_load pulse", int'(pc_load), 1);
    chk("R1 target value", int'(target), int'(e));
    chk("R7 stray start not accepted", int'(index_rd), 0);
    bus_ack = 1'b0; idx_in = $urandom;
    @(negedge clk);
    chk("R4 pc_load single cycle", int'(pc_load), 0);
    chk("R3 target held", int'(target), int'(e));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [ADDR_W-1:0] e;
    void'($urandom(32'd20240611));
    rst = 1'b1; step_en = 1'b1; br_start = 1'b0; bus_ack = 1'b0; idx_in = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset index_rd", int'(index_rd), 0);
    chk("R8 reset pc_load", int'(pc_load), 0);
    chk("R8 reset target", int'(target), 0);
    rst = 1'b0;

    // R9: bus_ack while idle does nothing
    bus_ack = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9 idle bus_ack no load", int'(pc_load), 0);
      chk("R9 idle bus_ack no index_rd", int'(index_rd), 0);
    end
    bus_ack = 1'b0;

    // R1 corners: zero, wrap boundary, top
    run_branch(8'h00, 0);
    run_branch(8'h80, 1);
    run_branch(8'hFF, 3);
    run_branch(8'h7F, 0);

    // R7: start with step_en low is ignored
    @(negedge clk); step_en = 1'b0; br_start = 1'b1;
    @(negedge clk); br_start = 1'b0;
    chk("R7 start ignored when frozen", int'(index_rd), 0);
    step_en = 1'b1;

    // R6: freeze during the request cycle and during stall
    @(negedge clk); br_start = 1'b1; idx_in = 8'h11;
    @(negedge clk); br_start = 1'b0; step_en = 1'b0; idx_in = 8'h22;
    @(negedge clk);
    chk("R6 index_rd held while frozen", int'(index_rd), 1);
    chk("R6 target unchanged while frozen", int'(target), int'(exp_tgt(8'h7F)));
    idx_in = 8'h5A;
    @(negedge clk);
    chk("R6 index_rd still held", int'(index_rd), 1);
    step_en = 1'b1;                                    // advance: samples 0x5A
    @(negedge clk);
    chk("R3 sampled on advancing edge", int'(target), int'(exp_tgt(8'h5A)));
    chk("R2 index_rd drops after advance", int'(index_rd), 0);
    step_en = 1'b0;
    @(negedge clk);
    chk("R6 no load while frozen", int'(pc_load), 0);
    step_en = 1'b1; bus_ack = 1'b1;
    @(negedge clk);
    chk("R5 stalled", int'(pc_load), 0);
    bus_ack = 1'b0; step_en = 1'b0;
    @(negedge clk);
    chk("R6 frozen in stall", int'(pc_load), 0);
    step_en = 1'b1;
    @(negedge clk);
    chk("R5 load after stall clears", int'(pc_load), 1);
    step_en = 1'b0;
    @(negedge clk);
    chk("R6 pc_load clears on frozen edge", int'(pc_load), 0);
    step_en = 1'b1;

    // random mix
    for (int k = 0; k < 40; k++) begin
      run_branch(IDX_W'($urandom), int'($urandom_range(4)));
      repeat ($urandom_range(2)) @(negedge clk);
    end

    // R8: reset mid-branch
    @(negedge clk); br_start = 1'b1;
    @(negedge clk); br_start = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset clears index_rd", int'(index_rd), 0);
    chk("R8 reset clears target", int'(target), 0);
    e = '0;
    @(negedge clk);
    chk("R8 idle after reset", int'(pc_load), int'(e[0]));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule